// File: doc/BRIEF.md
# Latched Channel-Select Controller with Break-Before-Make

This block is the clocked control path of a latched analog multiplexer. A host presents a channel address and an active-high enable. An active-low write strobe gates a pair of transparent holding stages for these two values. While the strobe is low, the selection follows the inputs. When the strobe returns high, the last value presented is kept, and later changes on the inputs are ignored. An active-low reset empties the holding stages, so every switch opens and stays open until a new write arrives.

The output is a one-hot vector of switch-enable lines with at most one line high. The parameter `DIFFERENTIAL` selects the form. With `DIFFERENTIAL = 0` the block decodes a 4-bit address onto 16 single-ended lines. With `DIFFERENTIAL = 1` it decodes a 3-bit address onto 8 lines, and each line closes a matched pair of switches.

A move from one live channel straight to a different live channel never happens directly. All lines first drop for `DEAD_CYCLES` clock cycles, and `bbmBusy` marks that gap. A move from all-off to a channel, or from a channel to all-off, takes effect at once. The strobes are assumed to be synchronous to `clk` already.

Top module: `latched_chan_sel`

## Requirements
- R1: While `wrN` is low, the address and enable sampled at a clock edge drive `swOn` directly after that edge, with no dead interval involved.
- R2: While `wrN` is high, `swOn` keeps the selection from the last edge at which `wrN` was low, and changes on `chanAddr` or `chanEn` have no effect.
- R3: Reset clears the held address and enable to zero, so `swOn` is all zeros. With `wrN` high after release, `swOn` stays all zeros.
- R4: When the effective enable is 0, `swOn` is all zeros after the next edge, whatever the address.
- R5: Address value N sets bit N of `swOn`, which is channel N+1. The address is 4 bits wide onto 16 lines in single-ended form and 3 bits wide onto 8 paired lines in differential form.
- R6: `swOn` never changes from one nonzero value to a different nonzero value between two consecutive cycles.
- R7: At most one bit of `swOn` is high in any cycle.
- R8: When a live channel is replaced by a different live channel, `swOn` is zero and `bbmBusy` is high for exactly `DEAD_CYCLES` cycles. The most recent requested channel then turns on.
- R9: A change from all-off to a channel, or from a channel to all-off, needs no dead interval, and `bbmBusy` stays low.
- R10: Reset takes priority over write. While `rstN` is low, `swOn` is zero even if `wrN` is low and `chanEn` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; clears the held address and enable |
| wrN | input | 1 | Active-low write strobe; the holding stages are transparent while it is low |
| chanEn | input | 1 | Active-high enable for the selected channel |
| chanAddr | input | ADDR_W (4 or 3) | Binary channel address |
| swOn | output | NUM_CH (16 or 8) | One-hot switch-enable lines |
| bbmBusy | output | 1 | High during a break-before-make dead interval |

## Verification
Every selection result appears on `swOn` one clock edge after the edge that samples the inputs. The one exception is a change between two live channels, which shows zeros with `bbmBusy` high for `DEAD_CYCLES` edges before the new line appears. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge. It compares `swOn` and `bbmBusy` with the model on the next falling edge, half a cycle after the edge that is due to change them. The directed checks for a dead interval count the falling edges that show `bbmBusy` high and `swOn` zero before the new channel appears. They expect that count to equal `DEAD_CYCLES`.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Strobes from the sequencing control to the selection datapath
  typedef struct packed {
    logic loadSel;   // take the requested selection
    logic clearSel;  // force all switches open
  } selStrobe_t;
endpackage

// File: rtl/csel_decode.sv
module csel_decode #(
  parameter int IDX_W  = 4,
  parameter int NUM_CH = 16
) (
  input  logic              valid,
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_CH-1:0] onehot
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_line
    assign onehot[g] = valid && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic              chanEn,
  input  logic [ADDR_W-1:0] chanAddr,
  input  selStrobe_t        strobe,
  output logic              reqChange,
  output logic              curOn,
  output logic [NUM_CH-1:0] swOn
);
  logic              heldEn;
  logic [ADDR_W-1:0] heldAddr;
  logic              effEn;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] curIdx;

  // Holding stages: transparent while the write strobe is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldEn   <= 1'b0;
      heldAddr <= '0;
    end else if (!wrN) begin
      heldEn   <= chanEn;
      heldAddr <= chanAddr;
    end
  end

  assign effEn   = wrN ? heldEn   : chanEn;
  assign effAddr = wrN ? heldAddr : chanAddr;

  assign reqChange = effEn && curOn && (effAddr != curIdx);

  // Selection register driven by the control strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOn  <= 1'b0;
      curIdx <= '0;
    end else if (strobe.clearSel) begin
      curOn  <= 1'b0;
    end else if (strobe.loadSel) begin
      curOn  <= effEn;
      curIdx <= effAddr;
    end
  end

  csel_decode #(.IDX_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
    .valid  (curOn),
    .idx    (curIdx),
    .onehot (swOn)
  );

  // R2: no update of the holding stages while write is high
  a_r2_hold_while_high: assert property (@(posedge clk) disable iff (!rstN)
    wrN |=> ($stable(heldEn) && $stable(heldAddr)));

  // R4: a disabled request leaves every switch open after the next edge
  a_r4_disable_opens: assert property (@(posedge clk) disable iff (!rstN)
    !effEn |=> !curOn);
endmodule

// File: rtl/csel_control.sv
module csel_control
  import csel_pkg::*;
#(
  parameter int DEAD_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqChange,
  input  logic       curOn,
  output selStrobe_t strobe,
  output logic       bbmBusy
);
  localparam int CNT_W = $clog2(DEAD_CYCLES + 1);

  logic [CNT_W-1:0] deadCnt;
  logic [CNT_W-1:0] deadCntNext;

  always_comb begin
    strobe      = '0;
    deadCntNext = deadCnt;
    if (deadCnt != '0) begin
      deadCntNext = deadCnt - CNT_W'(1);
      if (deadCnt == CNT_W'(1)) strobe.loadSel  = 1'b1;
      else                      strobe.clearSel = 1'b1;
    end else if (reqChange) begin
      strobe.clearSel = 1'b1;
      deadCntNext     = CNT_W'(DEAD_CYCLES);
    end else begin
      strobe.loadSel = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deadCnt <= '0;
    else       deadCnt <= deadCntNext;
  end

  assign bbmBusy = (deadCnt != '0);

  // R8: every switch is open throughout the dead interval
  a_r8_busy_means_open: assert property (@(posedge clk) disable iff (!rstN)
    bbmBusy |-> !curOn);

  // R9: a request from the all-off state never opens a dead interval
  a_r9_from_off_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (!curOn && !bbmBusy) |=> !bbmBusy);
endmodule

// File: rtl/latched_chan_sel.sv
module latched_chan_sel
  import csel_pkg::*;
#(
  parameter bit DIFFERENTIAL = 1'b0,
  parameter int DEAD_CYCLES  = 3,
  localparam int ADDR_W = DIFFERENTIAL ? 3 : 4,
  localparam int NUM_CH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic              chanEn,
  input  logic [ADDR_W-1:0] chanAddr,
  output logic [NUM_CH-1:0] swOn,
  output logic              bbmBusy
);
  selStrobe_t strobe;
  logic       reqChange;
  logic       curOn;

  csel_datapath #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wrN       (wrN),
    .chanEn    (chanEn),
    .chanAddr  (chanAddr),
    .strobe    (strobe),
    .reqChange (reqChange),
    .curOn     (curOn),
    .swOn      (swOn)
  );

  csel_control #(.DEAD_CYCLES(DEAD_CYCLES)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqChange (reqChange),
    .curOn     (curOn),
    .strobe    (strobe),
    .bbmBusy   (bbmBusy)
  );

  // R7: never more than one switch line high
  a_r7_onehot_out: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(swOn));

  // R6: no direct move between two live channels
  a_r6_break_first: assert property (@(posedge clk) disable iff (!rstN)
    ((swOn != '0) && ($past(swOn) != '0)) |-> (swOn == $past(swOn)));
endmodule

// File: tb/latched_chan_sel_tb.sv
module latched_chan_sel_tb;
  localparam int DEAD   = 3;
  localparam int NCH    = 16;

  logic           clk = 1'b0;
  logic           rstN, wrN, chanEn;
  logic [3:0]     chanAddr;
  logic [NCH-1:0] swOn;
  logic           bbmBusy;

  int checks = 0;
  int fails  = 0;
  string curReq = "R7";

  // behavioural reference state
  int mHeldEn, mHeldAddr, mOn, mIdx, mCnt;
  int eEn, eAddr;

  always #2.5 clk = ~clk;

  latched_chan_sel #(.DIFFERENTIAL(1'b0), .DEAD_CYCLES(DEAD)) u_dut (
    .clk(clk), .rstN(rstN), .wrN(wrN), .chanEn(chanEn),
    .chanAddr(chanAddr), .swOn(swOn), .bbmBusy(bbmBusy)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mHeldEn = 0; mHeldAddr = 0; mOn = 0; mIdx = 0; mCnt = 0;
    end else begin
      eEn   = wrN ? mHeldEn   : int'(chanEn);
      eAddr = wrN ? mHeldAddr : int'(chanAddr);
      if (!wrN) begin mHeldEn = int'(chanEn); mHeldAddr = int'(chanAddr); end
      if (mCnt > 0) begin
        if (mCnt == 1) begin mOn = eEn; mIdx = eAddr; end
        else mOn = 0;
        mCnt--;
      end else if (mOn != 0 && eEn != 0 && eAddr != mIdx) begin
        mOn = 0; mCnt = DEAD;
      end else begin
        mOn = eEn; mIdx = eAddr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expVec();
    return (mOn != 0) ? (1 << mIdx) : 0;
  endfunction

  // one clock, then compare against the model half a cycle after the edge
  task automatic step();
    @(negedge clk);
    chk(int'(swOn) == expVec(), curReq, int'(swOn), expVec());
    chk(int'(bbmBusy) == int'(mCnt != 0), curReq, int'(bbmBusy), int'(mCnt != 0));
    chk($countones(swOn) <= 1, "R7", int'(swOn), expVec());
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int busyCnt;
    rstN = 1'b0; wrN = 1'b1; chanEn = 1'b0; chanAddr = '0;
    curReq = "R3";
    step(); step();
    chk(swOn == '0 && !bbmBusy, "R3", int'(swOn), 0);
    rstN = 1'b1;
    step();

    // R1 R5 R9: every address from all-off, then back off
    wrN = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      curReq = "R5";
      chanEn = 1'b1; chanAddr = 4'(k);
      step();
      chk(int'(swOn) == (1 << k) && !bbmBusy, "R5", int'(swOn), 1 << k);
      curReq = "R9";
      chanEn = 1'b0;
      step();
      chk(swOn == '0 && !bbmBusy, "R9", int'(swOn), 0);
    end

    // R8 R6: live channel to live channel
    curReq = "R8";
    chanEn = 1'b1; chanAddr = 4'd3;
    step();
    chk(int'(swOn) == (1 << 3), "R1", int'(swOn), 1 << 3);
    chanAddr = 4'd9;
    busyCnt = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (int'(swOn) == (1 << 9)) break;
      if (bbmBusy && swOn == '0) busyCnt++;
    end
    chk(busyCnt == DEAD, "R8", busyCnt, DEAD);
    chk(int'(swOn) == (1 << 9), "R6", int'(swOn), 1 << 9);

    // R2: held while write high
    curReq = "R2";
    wrN = 1'b1; chanAddr = 4'd0; chanEn = 1'b0;
    step(); step(); step();
    chk(int'(swOn) == (1 << 9), "R2", int'(swOn), 1 << 9);

    // R4: enable low opens all
    curReq = "R4";
    wrN = 1'b0; chanEn = 1'b0; chanAddr = 4'd9;
    step();
    chk(swOn == '0, "R4", int'(swOn), 0);
    chanEn = 1'b1; chanAddr = 4'd6;
    step();
    curReq = "R2";
    wrN = 1'b1; chanAddr = 4'd12;
    step(); step();
    chk(int'(swOn) == (1 << 6), "R2", int'(swOn), 1 << 6);

    // R8: request changed again inside the dead interval
    curReq = "R8";
    wrN = 1'b0; chanAddr = 4'd4;
    step();
    chanAddr = 4'd11;
    repeat (DEAD) step();
    chk(int'(swOn) == (1 << 11), "R8", int'(swOn), 1 << 11);

    // R9: live channel to off is immediate
    curReq = "R9";
    chanEn = 1'b0;
    step();
    chk(swOn == '0 && !bbmBusy, "R9", int'(swOn), 0);

    // R10: reset wins over write
    curReq = "R10";
    chanEn = 1'b1; chanAddr = 4'd7; rstN = 1'b0;
    step();
    chk(swOn == '0, "R10", int'(swOn), 0);
    curReq = "R3";
    rstN = 1'b1; wrN = 1'b1;
    step(); step();
    chk(swOn == '0, "R3", int'(swOn), 0);
    curReq = "R1";
    wrN = 1'b0;
    step();
    chk(int'(swOn) == (1 << 7), "R1", int'(swOn), 1 << 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule